// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-interrupt programming state of an interrupt distributor and exposes it on a simple memory-mapped register port. For every implemented interrupt number it stores a group bit, an enable bit, a pending latch, an active bit, a priority and a trigger type (edge or level). Software reaches this state through 32-bit word accesses. Single-byte accesses are also accepted, but only on the priority array.

Enable, pending and active each appear twice in the map. One copy sets bits and the other clears them. Both copies read back the same current state. Each interrupt also has a line input. A level-triggered line shows up directly in the pending view. A rising edge on an edge-triggered line sets the pending latch. The complete state is exported as flat vectors so that a downstream arbiter can use it.

Interrupt numbers 0 to 15 are software-generated and 16 to 31 are private. Their trigger type is fixed. When the legacy option is enabled, software cannot change the pending state of numbers 0 to 15.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset, every ID is disabled, not pending, inactive, in group 0 and at priority 0. IDs 0–15 are edge-triggered and all other IDs are level-triggered. The trigger word at 0x800 reads 0xAAAAAAAA and the word at 0x804 reads 0.
- R2: The set-enable view (base 0x080) and the clear-enable view (base 0x100) hold one bit per ID, with ID n at word n/32, bit n%32. A write sets or clears only the IDs whose data bit is 1. Both views read back the same current enable state. The set/clear pairs for pending are at 0x180/0x200 and for active at 0x280/0x300.
- R3: A write to the group array (base 0x000, same bit layout) loads every addressed bit directly from the data, so written zeros take effect as well as ones.
- R4: Priority takes one byte per ID from base 0x400, with ID n in byte n. In a word access, ID 4k+j sits in bits 8j+7:8j. Only the top PRI_BITS bits of each byte are kept, and the low bits read as 0. A byte access writes bits 7:0 of the data to the addressed ID and returns that ID's byte in bits 7:0.
- R5: The trigger array (base 0x800) holds two bits per ID, with ID n at word n/16, bits 2(n%16)+1:2(n%16). For IDs 32 and above, the upper bit of the pair selects edge (1) or level (0), and the lower bit is ignored. A read returns 2'b10 for edge and 2'b00 for level.
- R6: Trigger writes to IDs below 32 are ignored, so those IDs keep their reset trigger type.
- R7: With LEGACY_SGI_WI set, set-pending and clear-pending writes to IDs 0–15 are ignored. Writes to the same word still act on IDs 16–31.
- R8: Active reads return only the stored active bits and never depend on the line inputs.
- R9: For a level-triggered ID, the pending read is the latch ORed with the current line. For an edge-triggered ID, it is the latch alone. A rising edge on an edge-triggered line sets the latch.
- R10: If a rising edge on an edge-triggered ID arrives in the same cycle as a clear-pending write to that ID, the latch ends up set.
- R11: Bits, bytes and pairs for IDs at or above NUM_IDS read as 0 and ignore writes.
- R12: A byte access outside the priority array, a word access with addr[1:0] not zero, and any unmapped address all read as 0 and leave the state unchanged.
- R13: grp_o, en_o, pend_o, act_o, edge_o and prio_o (byte n is ID n, in register form) always match what the register port reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = single-byte access, 0 = 32-bit word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data (a byte write uses bits 7:0) |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_line_i | input | NUM_IDS | Interrupt line level, one per ID |
| grp_o | output | NUM_IDS | Group bits |
| en_o | output | NUM_IDS | Enable bits |
| pend_o | output | NUM_IDS | Effective pending state |
| act_o | output | NUM_IDS | Active bits |
| edge_o | output | NUM_IDS | 1 = edge-triggered |
| prio_o | output | NUM_IDS*8 | Priority bytes |

## Verification
Two events can hit the same pending latch in one clock cycle: a rising edge on an edge-triggered line and a software clear-pending write. The bench sets up this collision by raising the line of an ID that was reprogrammed to edge at the same falling edge where it drives the clear write, so both are sampled at the same rising edge. It then reads the pending view and expects the bit to be set. A second clear, issued with the line held high, must drop the bit, which shows that a steady high line is not mistaken for a new edge.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   localparam int OFF_W = 10;

   typedef enum logic [3:0] {
      RG_GRP,
      RG_ENS,
      RG_ENC,
      RG_PDS,
      RG_PDC,
      RG_ACS,
      RG_ACC,
      RG_PRI,
      RG_CFG,
      RG_NONE
   } dist_region_e;

endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
   import irq_dist_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              byte_acc,
   output dist_region_e      region,
   output logic [OFF_W-1:0]  offs,
   output logic              acc_ok
);

   logic hi_ok;

   generate
      if (ADDR_W > 12) begin : g_hi
         assign hi_ok = ~|addr[ADDR_W-1:12];
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      region = RG_NONE;
      offs   = '0;
      unique case (addr[11:7])
         5'h00: begin region = RG_GRP; offs = {3'b000, addr[6:0]}; end
         5'h01: begin region = RG_ENS; offs = {3'b000, addr[6:0]}; end
         5'h02: begin region = RG_ENC; offs = {3'b000, addr[6:0]}; end
         5'h03: begin region = RG_PDS; offs = {3'b000, addr[6:0]}; end
         5'h04: begin region = RG_PDC; offs = {3'b000, addr[6:0]}; end
         5'h05: begin region = RG_ACS; offs = {3'b000, addr[6:0]}; end
         5'h06: begin region = RG_ACC; offs = {3'b000, addr[6:0]}; end
         5'h08, 5'h09, 5'h0A, 5'h0B,
         5'h0C, 5'h0D, 5'h0E, 5'h0F: begin region = RG_PRI; offs = addr[9:0]; end
         5'h10, 5'h11: begin region = RG_CFG; offs = {2'b00, addr[7:0]}; end
         default: begin region = RG_NONE; offs = '0; end
      endcase
   end

   // Bytes only reach the priority array; words must be aligned.
   assign acc_ok = hi_ok && (region != RG_NONE) &&
                   (byte_acc ? (region == RG_PRI) : (addr[1:0] == 2'b00));

endmodule

// File: rtl/irq_dist_cell.sv
module irq_dist_cell #(
   parameter int PRI_BITS = 5,
   parameter bit CFG_LOCK = 1'b0,
   parameter bit RST_EDGE = 1'b0,
   parameter bit PEND_WI  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_i,
   input  logic                grp_we,
   input  logic                grp_d,
   input  logic                en_set,
   input  logic                en_clr,
   input  logic                pd_set,
   input  logic                pd_clr,
   input  logic                ac_set,
   input  logic                ac_clr,
   input  logic                pri_we,
   input  logic [PRI_BITS-1:0] pri_d,
   input  logic                cfg_we,
   input  logic                cfg_d,
   output logic                grp_o,
   output logic                en_o,
   output logic                pend_o,
   output logic                act_o,
   output logic                edge_o,
   output logic [7:0]          pri_o
);

   logic                line_q;
   logic                rise;
   logic                latch_q;
   logic                sw_set;
   logic                sw_clr;
   logic [PRI_BITS-1:0] pri_q;

   assign rise = line_i & ~line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b0;
         grp_o   <= 1'b0;
         en_o    <= 1'b0;
         act_o   <= 1'b0;
         latch_q <= 1'b0;
         pri_q   <= '0;
      end else begin
         line_q <= line_i;
         if (grp_we) grp_o <= grp_d;
         if (en_set)      en_o <= 1'b1;
         else if (en_clr) en_o <= 1'b0;
         if (ac_set)      act_o <= 1'b1;
         else if (ac_clr) act_o <= 1'b0;
         // A fresh hardware edge outranks a software clear in the same cycle.
         if (edge_o && rise) latch_q <= 1'b1;
         else if (sw_set)    latch_q <= 1'b1;
         else if (sw_clr)    latch_q <= 1'b0;
         if (pri_we) pri_q <= pri_d;
      end
   end

   assign pend_o = latch_q | (~edge_o & line_i);

   generate
      if (PEND_WI) begin : g_pend_wi
         logic unused_pd;
         assign unused_pd = pd_set ^ pd_clr;
         assign sw_set    = 1'b0;
         assign sw_clr    = 1'b0;

         AST_SGI_PEND_WI: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_clr && pend_o && edge_o) |=> pend_o); // R7
      end else begin : g_pend_rw
         assign sw_set = pd_set;
         assign sw_clr = pd_clr;
      end

      if (CFG_LOCK) begin : g_cfg_fixed
         logic unused_cfg;
         assign unused_cfg = cfg_we ^ cfg_d;
         assign edge_o     = RST_EDGE;
      end else begin : g_cfg_rw
         logic edge_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      edge_q <= RST_EDGE;
            else if (cfg_we) edge_q <= cfg_d;
         end
         assign edge_o = edge_q;

         AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we |=> (edge_o == $past(cfg_d))); // R5
      end

      if (PRI_BITS == 8) begin : g_pri_full
         assign pri_o = pri_q;
      end else begin : g_pri_narrow
         assign pri_o = {pri_q, {(8-PRI_BITS){1'b0}}};
      end
   endgenerate

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> en_o); // R2
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr && !en_set) |=> !en_o); // R2
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_set && !en_clr) |=> $stable(en_o)); // R2
   AST_GRP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      grp_we |=> (grp_o == $past(grp_d))); // R3
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ac_set && !ac_clr) |=> $stable(act_o)); // R8
   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o && rise && pd_clr && !cfg_we) |=> pend_o); // R10

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irq_dist_pkg::*;
#(
   parameter int NUM_IDS       = 64,
   parameter int PRI_BITS      = 5,
   parameter int ADDR_W        = 12,
   parameter bit LEGACY_SGI_WI = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic                 bus_byte,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_IDS-1:0]   irq_line_i,
   output logic [NUM_IDS-1:0]   grp_o,
   output logic [NUM_IDS-1:0]   en_o,
   output logic [NUM_IDS-1:0]   pend_o,
   output logic [NUM_IDS-1:0]   act_o,
   output logic [NUM_IDS-1:0]   edge_o,
   output logic [NUM_IDS*8-1:0] prio_o
);

   localparam int SGI_IDS   = 16;
   localparam int PRIV_IDS  = 32;
   localparam int WORDS_1B  = NUM_IDS / 32;
   localparam int WORDS_PRI = NUM_IDS / 4;
   localparam int WORDS_CFG = NUM_IDS / 16;

   generate
      if (NUM_IDS < 32 || NUM_IDS > 1024 || (NUM_IDS % 32) != 0) begin : g_bad_ids
         $error("irq_dist_regs: NUM_IDS must be a multiple of 32 in 32..1024");
      end
      if (PRI_BITS < 1 || PRI_BITS > 8) begin : g_bad_pri
         $error("irq_dist_regs: PRI_BITS must be 1..8");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("irq_dist_regs: ADDR_W must be at least 12");
      end
   endgenerate

   dist_region_e           region;
   logic [OFF_W-1:0]       offs;
   logic [OFF_W-3:0]       wi;
   logic                   acc_ok;
   logic                   wr_ok;
   logic                   rd_ok;
   logic [2*NUM_IDS-1:0]   cfg_v;
   logic [NUM_IDS-1:0]     bitvec;
   logic [31:0]            rd_val;

   irq_dist_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .byte_acc (bus_byte),
      .region   (region),
      .offs     (offs),
      .acc_ok   (acc_ok)
   );

   assign wi    = offs[OFF_W-1:2];
   assign wr_ok = bus_sel &  bus_wr & acc_ok;
   assign rd_ok = bus_sel & ~bus_wr & acc_ok;

   generate
      for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
         localparam int W1  = i / 32;
         localparam int B1  = i % 32;
         localparam int W4  = i / 4;
         localparam int L4  = i % 4;
         localparam int W16 = i / 16;
         localparam int B16 = i % 16;

         logic                hit1;
         logic                bit_d;
         logic                pri_we;
         logic [PRI_BITS-1:0] pri_d;
         logic                cfg_we;

         assign hit1   = wr_ok && (int'(wi) == W1);
         assign bit_d  = bus_wdata[B1];
         assign pri_we = wr_ok && (region == RG_PRI) &&
                         (bus_byte ? (int'(offs) == i) : (int'(wi) == W4));
         assign pri_d  = bus_byte ? bus_wdata[7 -: PRI_BITS]
                                  : bus_wdata[8*L4+7 -: PRI_BITS];
         assign cfg_we = wr_ok && (region == RG_CFG) && (int'(wi) == W16);

         irq_dist_cell #(
            .PRI_BITS (PRI_BITS),
            .CFG_LOCK (i < PRIV_IDS),
            .RST_EDGE (i < SGI_IDS),
            .PEND_WI  (LEGACY_SGI_WI && (i < SGI_IDS))
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (irq_line_i[i]),
            .grp_we (hit1 && region == RG_GRP),
            .grp_d  (bit_d),
            .en_set (hit1 && region == RG_ENS && bit_d),
            .en_clr (hit1 && region == RG_ENC && bit_d),
            .pd_set (hit1 && region == RG_PDS && bit_d),
            .pd_clr (hit1 && region == RG_PDC && bit_d),
            .ac_set (hit1 && region == RG_ACS && bit_d),
            .ac_clr (hit1 && region == RG_ACC && bit_d),
            .pri_we (pri_we),
            .pri_d  (pri_d),
            .cfg_we (cfg_we),
            .cfg_d  (bus_wdata[2*B16+1]),
            .grp_o  (grp_o[i]),
            .en_o   (en_o[i]),
            .pend_o (pend_o[i]),
            .act_o  (act_o[i]),
            .edge_o (edge_o[i]),
            .pri_o  (prio_o[8*i +: 8])
         );

         assign cfg_v[2*i+1] = edge_o[i];
         assign cfg_v[2*i]   = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (region)
         RG_GRP:         bitvec = grp_o;
         RG_ENS, RG_ENC: bitvec = en_o;
         RG_PDS, RG_PDC: bitvec = pend_o;
         RG_ACS, RG_ACC: bitvec = act_o;
         default:        bitvec = '0;
      endcase
   end

   always_comb begin
      rd_val = '0;
      unique case (region)
         RG_PRI: begin
            if (bus_byte) begin
               if (int'(offs) < NUM_IDS) rd_val[7:0] = prio_o[int'(offs)*8 +: 8];
            end else if (int'(wi) < WORDS_PRI) begin
               rd_val = prio_o[int'(wi)*32 +: 32];
            end
         end
         RG_CFG: if (int'(wi) < WORDS_CFG) rd_val = cfg_v[int'(wi)*32 +: 32];
         RG_NONE: rd_val = '0;
         default: if (int'(wi) < WORDS_1B) rd_val = bitvec[int'(wi)*32 +: 32];
      endcase
   end

   assign bus_rdata = rd_ok ? rd_val : '0;

   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !acc_ok) |-> (bus_rdata == 32'h0)); // R12

endmodule

// File: tb/irq_dist_regs_test.sv
module irq_dist_regs_test;

   localparam int CLK_PERIOD = 10;
   localparam int NIDS       = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel = 1'b0;
   logic             wr = 1'b0;
   logic             byt = 1'b0;
   logic [11:0]      addr = '0;
   logic [31:0]      wdata = '0;
   logic [31:0]      rdata;
   logic [NIDS-1:0]  lines = '0;
   logic [NIDS-1:0]  grp_o, en_o, pend_o, act_o, edge_o;
   logic [NIDS*8-1:0] prio_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_dist_regs #(.NUM_IDS(NIDS), .PRI_BITS(5), .ADDR_W(12), .LEGACY_SGI_WI(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_byte(byt),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_line_i(lines),
      .grp_o(grp_o), .en_o(en_o), .pend_o(pend_o), .act_o(act_o), .edge_o(edge_o),
      .prio_o(prio_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic b);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d; byt = b;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; byt = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [11:0] a, input logic b, output logic [31:0] v);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a; byt = b;
      #1 v = rdata;
      sel = 1'b0; byt = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic b, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, b, v);
      check(req, {32'h0, v}, {32'h0, exp});
   endtask

   task automatic t_reset;
      rd_check("R1 enable word0", 12'h080, 1'b0, 32'h0);
      rd_check("R1 pending word1", 12'h184, 1'b0, 32'h0);
      rd_check("R1 trigger word0 edge", 12'h800, 1'b0, 32'hAAAA_AAAA);
      rd_check("R1 trigger word1 level", 12'h804, 1'b0, 32'h0);
      rd_check("R1 priority", 12'h420, 1'b0, 32'h0);
      check("R1 edge_o", edge_o, 64'h0000_0000_0000_FFFF);
      check("R1 state vectors", grp_o | en_o | pend_o | act_o, 64'h0);
   endtask

   task automatic t_enable;
      bus_write(12'h080, 32'h5, 1'b0);
      rd_check("R2 set view", 12'h080, 1'b0, 32'h5);
      rd_check("R2 clear view same", 12'h100, 1'b0, 32'h5);
      bus_write(12'h080, 32'h2, 1'b0);
      rd_check("R2 set adds only ones", 12'h080, 1'b0, 32'h7);
      bus_write(12'h100, 32'h4, 1'b0);
      rd_check("R2 clear only ones", 12'h100, 1'b0, 32'h3);
      bus_write(12'h100, 32'h0, 1'b0);
      rd_check("R2 zero clear no effect", 12'h080, 1'b0, 32'h3);
   endtask

   task automatic t_group;
      bus_write(12'h004, 32'hA5A5_0000, 1'b0);
      rd_check("R3 group load", 12'h004, 1'b0, 32'hA5A5_0000);
      bus_write(12'h004, 32'h0000_0001, 1'b0);
      rd_check("R3 group zeros take effect", 12'h004, 1'b0, 32'h0000_0001);
   endtask

   task automatic t_priority;
      bus_write(12'h420, 32'hFFFF_FF7F, 1'b0);
      rd_check("R4 word narrowed", 12'h420, 1'b0, 32'hF8F8_F878);
      bus_write(12'h422, 32'h0000_0013, 1'b1);
      rd_check("R4 byte write", 12'h420, 1'b0, 32'hF810_F878);
      rd_check("R4 byte read", 12'h421, 1'b1, 32'h0000_00F8);
   endtask

   task automatic t_config;
      bus_write(12'h808, 32'h0000_000A, 1'b0);
      rd_check("R5 edge pairs", 12'h808, 1'b0, 32'h0000_000A);
      bus_write(12'h808, 32'h0000_0005, 1'b0);
      rd_check("R5 low bit ignored level", 12'h808, 1'b0, 32'h0);
      bus_write(12'h808, 32'h0002_0000, 1'b0);
      rd_check("R5 id40 edge", 12'h808, 1'b0, 32'h0002_0000);
      bus_write(12'h800, 32'h0, 1'b0);
      bus_write(12'h804, 32'hFFFF_FFFF, 1'b0);
      rd_check("R6 sgi trigger locked", 12'h800, 1'b0, 32'hAAAA_AAAA);
      rd_check("R6 private trigger locked", 12'h804, 1'b0, 32'h0);
   endtask

   task automatic t_legacy;
      @(negedge clk); lines[3] = 1'b1;
      @(negedge clk); lines[3] = 1'b0;
      rd_check("R7 sgi edge latched", 12'h180, 1'b0, 32'h0000_0008);
      bus_write(12'h180, 32'hFFFF_FFFF, 1'b0);
      rd_check("R7 set-pending sgi ignored", 12'h180, 1'b0, 32'hFFFF_0008);
      bus_write(12'h200, 32'hFFFF_FFFF, 1'b0);
      rd_check("R7 clear-pending sgi ignored", 12'h200, 1'b0, 32'h0000_0008);
   endtask

   task automatic t_active;
      bus_write(12'h284, 32'h0000_00F0, 1'b0);
      rd_check("R8 set-active view", 12'h284, 1'b0, 32'h0000_00F0);
      rd_check("R8 clear-active view", 12'h304, 1'b0, 32'h0000_00F0);
      @(negedge clk); lines[36] = 1'b1;
      @(negedge clk);
      rd_check("R8 active ignores line", 12'h284, 1'b0, 32'h0000_00F0);
      lines[36] = 1'b0;
      bus_write(12'h304, 32'h0000_0010, 1'b0);
      rd_check("R8 clear active", 12'h284, 1'b0, 32'h0000_00E0);
   endtask

   task automatic t_pending;
      @(negedge clk); lines[40] = 1'b1;
      rd_check("R9 edge rise latched", 12'h184, 1'b0, 32'h0000_0100);
      lines[40] = 1'b0;
      @(negedge clk);
      rd_check("R9 edge latch holds", 12'h184, 1'b0, 32'h0000_0100);
      bus_write(12'h204, 32'h0000_0100, 1'b0);
      rd_check("R9 edge clear", 12'h184, 1'b0, 32'h0);
      @(negedge clk); lines[50] = 1'b1;
      rd_check("R9 level follows line", 12'h184, 1'b0, 32'h0004_0000);
      lines[50] = 1'b0;
      rd_check("R9 level line low", 12'h184, 1'b0, 32'h0);
      bus_write(12'h184, 32'h0004_0000, 1'b0);
      rd_check("R9 level latch set", 12'h184, 1'b0, 32'h0004_0000);
      bus_write(12'h204, 32'h0004_0000, 1'b0);
      rd_check("R9 level latch clear", 12'h184, 1'b0, 32'h0);
   endtask

   task automatic t_collision;
      @(negedge clk);
      lines[40] = 1'b1;
      sel = 1'b1; wr = 1'b1; addr = 12'h204; wdata = 32'h0000_0100; byt = 1'b0;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
      rd_check("R10 edge beats clear", 12'h184, 1'b0, 32'h0000_0100);
      bus_write(12'h204, 32'h0000_0100, 1'b0);
      rd_check("R10 steady line no new edge", 12'h184, 1'b0, 32'h0);
      @(negedge clk); lines[40] = 1'b0;
   endtask

   task automatic t_range;
      bus_write(12'h088, 32'hFFFF_FFFF, 1'b0);
      rd_check("R11 enable beyond ids", 12'h088, 1'b0, 32'h0);
      check("R11 en_o untouched", en_o, 64'h3);
      bus_write(12'h440, 32'hFFFF_FFFF, 1'b0);
      rd_check("R11 priority beyond ids", 12'h440, 1'b0, 32'h0);
      rd_check("R11 trigger beyond ids", 12'h810, 1'b0, 32'h0);
   endtask

   task automatic t_access;
      bus_write(12'h080, 32'h0000_00FF, 1'b1);
      rd_check("R12 byte write outside priority", 12'h080, 1'b0, 32'h3);
      bus_write(12'h081, 32'hFFFF_FFFF, 1'b0);
      rd_check("R12 misaligned word write", 12'h080, 1'b0, 32'h3);
      rd_check("R12 byte read outside priority", 12'h080, 1'b1, 32'h0);
      rd_check("R12 misaligned word read", 12'h422, 1'b0, 32'h0);
      rd_check("R12 unmapped gap", 12'h380, 1'b0, 32'h0);
   endtask

   task automatic t_exports;
      @(negedge clk);
      check("R13 grp_o", grp_o, 64'h0000_0001_0000_0000);
      check("R13 en_o", en_o, 64'h3);
      check("R13 act_o", act_o, 64'h0000_00E0_0000_0000);
      check("R13 edge_o", edge_o, 64'h0000_0100_0000_FFFF);
      check("R13 pend_o", pend_o, 64'h8);
      check("R13 prio_o id34", {56'h0, prio_o[34*8 +: 8]}, 64'h10);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_group();
      t_priority();
      t_config();
      t_legacy();
      t_active();
      t_pending();
      t_collision();
      t_range();
      t_access();
      t_exports();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule